// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Frame-Size-Dependent Depth

This block sits between the register interface and the serial shifter of an SPI master. It holds one transmit queue and one receive queue. Each queue keeps 32-bit words in a physical store of 32 entries. Software writes words into the transmit queue and the shifter takes them out. The shifter writes each received word into the receive queue and software reads it back.

The number of entries actually used, called the effective depth, is shared by both queues. With the large-queue enable off it is 4. With it on, the depth follows the configured frame size: 32 entries for frames of up to 8 bits, 16 entries for frames of 9 to 16 bits, and 8 entries for longer frames. A new depth is taken up only while both queues are empty, so a stored count can never exceed the depth in force.

Each queue reports registered flags for full, one-short-of-full and empty. The receive queue also keeps a sticky overflow status and a raw overflow interrupt flag.

Top module: `spi_fifo_pair`

## Requirements
- R1: After synchronous reset both queues are empty: the empty flags are 1, the full and full-next flags are 0, the overflow status and raw interrupt flags are 0, and the effective depth is 4.
- R2: Each queue returns words in the order they were pushed. A pop presents its word on the pop-data output in the cycle after the pop strobe.
- R3: With the large-queue enable at 0, full-next is 1 once a queue holds 3 words, and full is 1 (with full-next 0) once it holds 4.
- R4: With the enable at 1 and a frame size from 1 to 8, the depth is 32: full-next at 31 words and full at 32.
- R5: With the enable at 1 and a frame size from 9 to 16, the depth is 16.
- R6: With the enable at 1 and a frame size of 17 or more, the depth is 8.
- R7: A transmit push while the transmit count equals the depth is discarded. Popping the queue afterwards yields exactly the earlier depth words.
- R8: A receive push while the receive count equals the depth is discarded and sets both the receive overflow status and the raw overflow interrupt flag to 1.
- R9: A receive pop clears the receive overflow status and the full flag. The empty flag becomes 1 when the last word is popped.
- R10: A pop from an empty queue returns 0 on pop-data and leaves the flags unchanged.
- R11: The raw overflow interrupt flag stays set through receive pops and is cleared only by the interrupt-clear input. A new overflow in the same cycle wins over the clear.
- R12: A change of enable or frame size is applied only in a cycle where both queues are empty. While either queue holds data the previous depth stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_fifo_en | input | 1 | Large-queue enable |
| frame_size | input | 6 | Configured frame length in bits |
| tx_push | input | 1 | Register-side write strobe into the transmit queue |
| tx_push_data | input | 32 | Word to write into the transmit queue |
| tx_pop | input | 1 | Shifter-side read strobe from the transmit queue |
| tx_pop_data | output | 32 | Word read from the transmit queue, valid the cycle after tx_pop |
| rx_push | input | 1 | Shifter-side write strobe into the receive queue |
| rx_push_data | input | 32 | Received word |
| rx_pop | input | 1 | Register-side read strobe from the receive queue |
| rx_pop_data | output | 32 | Word read from the receive queue, valid the cycle after rx_pop |
| rx_irq_clr | input | 1 | Clears the raw receive overflow interrupt flag |
| tx_full | output | 1 | Transmit count equals depth |
| tx_full_next | output | 1 | Transmit count equals depth minus one |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive count equals depth |
| rx_full_next | output | 1 | Receive count equals depth minus one |
| rx_empty | output | 1 | Receive queue empty |
| rx_overflow | output | 1 | Sticky receive overflow status |
| rx_ovf_irq | output | 1 | Raw receive overflow interrupt flag |

## Verification
The depth selection is exercised with each frame-size class at both of its edges (1 and 8, 9 and 16, 17 and 32) and with the large-queue enable off. In each case the queue is filled to one short of full, then to full, then once past full, and finally drained. This shows the flag thresholds, the dropped extra word and the preserved order for every depth. The receive queue is overfilled to tell the sticky status, which a pop clears, apart from the raw interrupt flag, which only the clear input resets. A configuration change made while one queue still holds a word shows that the old depth remains in force until both queues have drained.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // Depth classes picked from the enable and frame length.
  typedef enum logic [1:0] {
    DCLS_SMALL  = 2'd0,
    DCLS_NARROW = 2'd1,
    DCLS_MID    = 2'd2,
    DCLS_WIDE   = 2'd3
  } depth_cls_e;

  // Frame-length thresholds (inclusive upper bounds).
  localparam int unsigned NARROW_FRAME_MAX = 8;
  localparam int unsigned MID_FRAME_MAX    = 16;

  typedef struct packed {
    logic full;
    logic full_next;
    logic empty;
  } fifo_flags_t;

endpackage

// File: rtl/spf_depth_ctrl.sv
module spf_depth_ctrl
  import spf_pkg::*;
#(
  parameter int unsigned FSZ_W        = 6,
  parameter int unsigned CNT_W        = 6,
  parameter int unsigned SMALL_DEPTH  = 4,
  parameter int unsigned NARROW_DEPTH = 32,
  parameter int unsigned MID_DEPTH    = 16,
  parameter int unsigned WIDE_DEPTH   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             big_en,
  input  logic [FSZ_W-1:0] frame_size,
  input  logic             tx_idle,
  input  logic             rx_idle,
  output logic [CNT_W-1:0] depth_q,
  output logic [CNT_W-1:0] depth_nxt
);

  localparam logic [FSZ_W-1:0] NARROW_LIM = FSZ_W'(NARROW_FRAME_MAX);
  localparam logic [FSZ_W-1:0] MID_LIM    = FSZ_W'(MID_FRAME_MAX);

  depth_cls_e       cls;
  logic [CNT_W-1:0] depth_req;

  always_comb begin
    if (!big_en)                    cls = DCLS_SMALL;
    else if (frame_size <= NARROW_LIM) cls = DCLS_NARROW;
    else if (frame_size <= MID_LIM)    cls = DCLS_MID;
    else                            cls = DCLS_WIDE;
  end

  always_comb begin
    unique case (cls)
      DCLS_SMALL:  depth_req = CNT_W'(SMALL_DEPTH);
      DCLS_NARROW: depth_req = CNT_W'(NARROW_DEPTH);
      DCLS_MID:    depth_req = CNT_W'(MID_DEPTH);
      default:     depth_req = CNT_W'(WIDE_DEPTH);
    endcase
  end

  // A new depth is adopted only while nothing is stored anywhere.
  assign depth_nxt = (tx_idle && rx_idle) ? depth_req : depth_q;

  always_ff @(posedge clk) begin
    if (rst) depth_q <= CNT_W'(SMALL_DEPTH);
    else     depth_q <= depth_nxt;
  end

endmodule

// File: rtl/spf_fifo.sv
module spf_fifo
  import spf_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PHYS_DEPTH = 32,
  parameter int unsigned CNT_W      = $clog2(PHYS_DEPTH + 1),
  parameter bit          OVF_TRACK  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  depth_q,
  input  logic [CNT_W-1:0]  depth_nxt,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output fifo_flags_t       flags,
  input  logic              irq_clr,
  output logic              overflow,
  output logic              ovf_irq
);

  localparam int unsigned PTR_W = $clog2(PHYS_DEPTH);

  logic [DATA_W-1:0] mem [PHYS_DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              accept, take, drop;

  assign drop    = push && (cnt == depth_q);
  assign accept  = push && !drop;
  assign take    = pop && (cnt != '0);
  assign cnt_nxt = cnt + CNT_W'(accept) - CNT_W'(take);

  // Storage: write port and registered read port, no reset on the array.
  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)      pop_data <= '0;
    else if (pop) pop_data <= take ? mem[rptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept) wptr <= wptr + PTR_W'(1);
      if (take)   rptr <= rptr + PTR_W'(1);
      cnt <= cnt_nxt;
    end
  end

  // Flags registered against the depth that holds in the next cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      flags.full      <= 1'b0;
      flags.full_next <= 1'b0;
      flags.empty     <= 1'b1;
    end else begin
      flags.full      <= (cnt_nxt == depth_nxt);
      flags.full_next <= (cnt_nxt == depth_nxt - CNT_W'(1));
      flags.empty     <= (cnt_nxt == '0);
    end
  end

  generate
    if (OVF_TRACK) begin : g_ovf
      always_ff @(posedge clk) begin
        if (rst) begin
          overflow <= 1'b0;
          ovf_irq  <= 1'b0;
        end else begin
          if (drop)     overflow <= 1'b1;
          else if (pop) overflow <= 1'b0;
          if (drop)         ovf_irq <= 1'b1;
          else if (irq_clr) ovf_irq <= 1'b0;
        end
      end
    end else begin : g_no_ovf
      logic irq_clr_unused;
      assign irq_clr_unused = irq_clr;
      assign overflow = 1'b0;
      assign ovf_irq  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spf_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PHYS_DEPTH   = 32,
  parameter int unsigned FSZ_W        = 6,
  parameter int unsigned SMALL_DEPTH  = 4,
  parameter int unsigned NARROW_DEPTH = 32,
  parameter int unsigned MID_DEPTH    = 16,
  parameter int unsigned WIDE_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_fifo_en,
  input  logic [FSZ_W-1:0]  frame_size,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  input  logic              rx_irq_clr,
  output logic              tx_full,
  output logic              tx_full_next,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_full_next,
  output logic              rx_empty,
  output logic              rx_overflow,
  output logic              rx_ovf_irq
);

  localparam int unsigned CNT_W = $clog2(PHYS_DEPTH + 1);

  logic [CNT_W-1:0] depth_q, depth_nxt;
  fifo_flags_t      tx_flags, rx_flags;
  logic             tx_ovf_unused, tx_irq_unused;

  spf_depth_ctrl #(
    .FSZ_W(FSZ_W), .CNT_W(CNT_W), .SMALL_DEPTH(SMALL_DEPTH),
    .NARROW_DEPTH(NARROW_DEPTH), .MID_DEPTH(MID_DEPTH), .WIDE_DEPTH(WIDE_DEPTH)
  ) u_depth (
    .clk(clk), .rst(rst), .big_en(big_fifo_en), .frame_size(frame_size),
    .tx_idle(tx_flags.empty), .rx_idle(rx_flags.empty),
    .depth_q(depth_q), .depth_nxt(depth_nxt)
  );

  spf_fifo #(
    .DATA_W(DATA_W), .PHYS_DEPTH(PHYS_DEPTH), .CNT_W(CNT_W), .OVF_TRACK(1'b0)
  ) u_tx (
    .clk(clk), .rst(rst), .depth_q(depth_q), .depth_nxt(depth_nxt),
    .push(tx_push), .push_data(tx_push_data), .pop(tx_pop), .pop_data(tx_pop_data),
    .flags(tx_flags), .irq_clr(1'b0), .overflow(tx_ovf_unused), .ovf_irq(tx_irq_unused)
  );

  spf_fifo #(
    .DATA_W(DATA_W), .PHYS_DEPTH(PHYS_DEPTH), .CNT_W(CNT_W), .OVF_TRACK(1'b1)
  ) u_rx (
    .clk(clk), .rst(rst), .depth_q(depth_q), .depth_nxt(depth_nxt),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_pop), .pop_data(rx_pop_data),
    .flags(rx_flags), .irq_clr(rx_irq_clr), .overflow(rx_overflow), .ovf_irq(rx_ovf_irq)
  );

  assign tx_full      = tx_flags.full;
  assign tx_full_next = tx_flags.full_next;
  assign tx_empty     = tx_flags.empty;
  assign rx_full      = rx_flags.full;
  assign rx_full_next = rx_flags.full_next;
  assign rx_empty     = rx_flags.empty;

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_push,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              rx_pop,
  input logic [DATA_W-1:0] rx_pop_data,
  input logic [DATA_W-1:0] tx_pop_data,
  input logic              rx_irq_clr,
  input logic              tx_full,
  input logic              tx_full_next,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_full_next,
  input logic              rx_empty,
  input logic              rx_overflow,
  input logic              rx_ovf_irq
);

  // R1: reset leaves both queues empty with no overflow
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (tx_empty && rx_empty && !tx_full && !rx_full && !rx_overflow && !rx_ovf_irq));

  // R3: full, full-next and empty are mutually exclusive
  a_r3_tx_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_full, tx_full_next, tx_empty}));
  a_r3_rx_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_full, rx_full_next, rx_empty}));

  // R7: a push into a full transmit queue without a pop keeps it full
  a_r7_tx_drop: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_full && !tx_pop) |=> tx_full);

  // R8: a push into a full receive queue raises overflow and interrupt
  a_r8_rx_ovf: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> (rx_overflow && rx_ovf_irq));

  // R9: a receive pop without a new overflow clears the status
  a_r9_pop_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !(rx_push && rx_full)) |=> !rx_overflow);

  // R10: popping an empty queue returns zero
  a_r10_rx_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> (rx_pop_data == '0));
  a_r10_tx_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_empty) |=> (tx_pop_data == '0));

  // R11: the raw interrupt rises only on a dropped push and falls only on a clear
  a_r11_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf_irq) |-> $past(rx_push && rx_full));
  a_r11_irq_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ovf_irq) |-> $past(rx_irq_clr));

endmodule

bind spi_fifo_pair spf_checker #(.DATA_W(DATA_W)) u_spf_checker (
  .clk(clk), .rst(rst), .tx_push(tx_push), .tx_pop(tx_pop),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
  .tx_pop_data(tx_pop_data), .rx_irq_clr(rx_irq_clr),
  .tx_full(tx_full), .tx_full_next(tx_full_next), .tx_empty(tx_empty),
  .rx_full(rx_full), .rx_full_next(rx_full_next), .rx_empty(rx_empty),
  .rx_overflow(rx_overflow), .rx_ovf_irq(rx_ovf_irq)
);

// File: tb/test_spi_fifo_pair.sv
module test_spi_fifo_pair;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_fifo_en = 1'b0;
  logic [5:0]  frame_size = 6'd4;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic        rx_irq_clr = 1'b0;
  logic [31:0] tx_push_data = '0, rx_push_data = '0;
  logic [31:0] tx_pop_data, rx_pop_data;
  logic        tx_full, tx_full_next, tx_empty;
  logic        rx_full, rx_full_next, rx_empty, rx_overflow, rx_ovf_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_pair i_spi_fifo_pair (
    .clk(clk), .rst(rst), .big_fifo_en(big_fifo_en), .frame_size(frame_size),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
    .tx_pop_data(tx_pop_data), .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_irq_clr(rx_irq_clr),
    .tx_full(tx_full), .tx_full_next(tx_full_next), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_full_next(rx_full_next), .rx_empty(rx_empty),
    .rx_overflow(rx_overflow), .rx_ovf_irq(rx_ovf_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Each strobe is high for exactly one rising edge; results read at the following falling edge.
  task automatic tx_write(input logic [31:0] d);
    @(negedge clk); tx_push = 1'b1; tx_push_data = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic tx_read(output logic [31:0] d);
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0; d = tx_pop_data;
  endtask

  task automatic rx_write(input logic [31:0] d);
    @(negedge clk); rx_push = 1'b1; rx_push_data = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic rx_read(output logic [31:0] d);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0; d = rx_pop_data;
  endtask

  task automatic set_cfg(input logic big, input logic [5:0] fs);
    @(negedge clk); big_fifo_en = big; frame_size = fs;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 tx_empty", 32'(tx_empty), 32'd1);
    chk("R1 rx_empty", 32'(rx_empty), 32'd1);
    chk("R1 full flags", {28'd0, tx_full, tx_full_next, rx_full, rx_full_next}, 32'd0);
    chk("R1 overflow/irq", {30'd0, rx_overflow, rx_ovf_irq}, 32'd0);
  endtask

  task automatic t_small;
    logic [31:0] d;
    set_cfg(1'b0, 6'd8);
    for (int i = 0; i < 3; i++) tx_write(32'h5A00_0000 + 32'(i));
    chk("R3 full_next at 3", {30'd0, tx_full, tx_full_next}, 32'd1);
    tx_write(32'h5A00_0003);
    chk("R3 full at 4", {30'd0, tx_full, tx_full_next}, 32'd2);
    tx_write(32'hDEAD_BEEF);
    chk("R7 still full after drop", 32'(tx_full), 32'd1);
    for (int i = 0; i < 4; i++) begin
      tx_read(d);
      chk("R2 tx order", d, 32'h5A00_0000 + 32'(i));
    end
    chk("R7 empty after depth pops", 32'(tx_empty), 32'd1);
    tx_read(d);
    chk("R10 tx empty pop zero", d, 32'd0);
    chk("R10 tx flags unchanged", {29'd0, tx_full, tx_full_next, tx_empty}, 32'd1);
  endtask

  task automatic t_rx_ovf;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) rx_write(32'hC000_0000 + 32'(i));
    chk("R3 rx full at 4", 32'(rx_full), 32'd1);
    chk("R8 no overflow yet", 32'(rx_overflow), 32'd0);
    rx_write(32'hBAD0_0000);
    chk("R8 overflow set", 32'(rx_overflow), 32'd1);
    chk("R8 irq set", 32'(rx_ovf_irq), 32'd1);
    rx_read(d);
    chk("R2 rx first word", d, 32'hC000_0000);
    chk("R9 overflow cleared by pop", 32'(rx_overflow), 32'd0);
    chk("R9 full cleared by pop", 32'(rx_full), 32'd0);
    chk("R11 irq held through pop", 32'(rx_ovf_irq), 32'd1);
    @(negedge clk); rx_irq_clr = 1'b1;
    @(negedge clk); rx_irq_clr = 1'b0;
    chk("R11 irq cleared", 32'(rx_ovf_irq), 32'd0);
    for (int i = 1; i < 4; i++) begin
      rx_read(d);
      chk("R8 dropped word absent", d, 32'hC000_0000 + 32'(i));
    end
    chk("R9 empty after drain", 32'(rx_empty), 32'd1);
    rx_read(d);
    chk("R10 rx empty pop zero", d, 32'd0);
    chk("R10 rx flags unchanged", {28'd0, rx_empty, rx_full, rx_overflow, rx_ovf_irq}, 32'd8);
    // overflow together with clear: the overflow wins
    for (int i = 0; i < 4; i++) rx_write(32'(i));
    @(negedge clk); rx_push = 1'b1; rx_irq_clr = 1'b1;
    @(negedge clk); rx_push = 1'b0; rx_irq_clr = 1'b0;
    chk("R11 overflow beats clear", 32'(rx_ovf_irq), 32'd1);
    for (int i = 0; i < 4; i++) rx_read(d);
    @(negedge clk); rx_irq_clr = 1'b1;
    @(negedge clk); rx_irq_clr = 1'b0;
  endtask

  task automatic t_depth(input string tag, input logic [5:0] fs, input int dep);
    logic [31:0] d;
    set_cfg(1'b1, fs);
    for (int i = 0; i < dep - 1; i++) tx_write(32'hA000_0000 + 32'(i));
    chk({tag, " full_next"}, {30'd0, tx_full, tx_full_next}, 32'd1);
    tx_write(32'hA000_0000 + 32'(dep - 1));
    chk({tag, " full"}, {30'd0, tx_full, tx_full_next}, 32'd2);
    tx_write(32'hFFFF_FFFF);
    for (int i = 0; i < dep; i++) begin
      tx_read(d);
      if (i == dep - 1) chk({tag, " R7 last word"}, d, 32'hA000_0000 + 32'(i));
      else if (d !== 32'hA000_0000 + 32'(i)) chk({tag, " R2 order"}, d, 32'hA000_0000 + 32'(i));
    end
    chk({tag, " R7 empty after depth pops"}, 32'(tx_empty), 32'd1);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    set_cfg(1'b0, 6'd8);
    rx_write(32'h1234_5678);
    set_cfg(1'b1, 6'd8);
    for (int i = 0; i < 3; i++) tx_write(32'(i));
    chk("R12 old depth full_next", 32'(tx_full_next), 32'd1);
    tx_write(32'd3);
    chk("R12 old depth full", 32'(tx_full), 32'd1);
    for (int i = 0; i < 4; i++) tx_read(d);
    rx_read(d);
    chk("R12 rx word kept", d, 32'h1234_5678);
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 4; i++) tx_write(32'(i));
    chk("R12 new depth applied", {30'd0, tx_full, tx_full_next}, 32'd0);
    for (int i = 0; i < 4; i++) tx_read(d);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_small();
    t_rx_ovf();
    t_depth("R4 fs1",  6'd1,  32);
    t_depth("R4 fs8",  6'd8,  32);
    t_depth("R5 fs9",  6'd9,  16);
    t_depth("R5 fs16", 6'd16, 16);
    t_depth("R6 fs17", 6'd17, 8);
    t_depth("R6 fs32", 6'd32, 8);
    t_hold();
    finish_run();
  end

endmodule